// File: doc/BRIEF.md
# Serial DAC Register Front End

This block takes 16-bit words from a three-wire serial port and places their contents in the register file of a multi-channel DAC. A word is framed by an active-low frame sync. Its bits arrive most significant bit first and are sampled on falling edges of the serial clock. The serial inputs are synchronised into the system clock domain, and the falling serial-clock edges are detected there. A word counts only when exactly sixteen bits arrive before the frame sync goes high again. When it counts, two mode bits send it to one of three targets: a global setup register, a per-channel setup register, or a channel's main (10-bit) or sub (8-bit) data register.

Each data register is double buffered. A second register behind it drives the converter, and only that second register appears on the outputs. Holding the load input low copies every data register into its DAC register on every clock. If the load input is already low when the sixteenth bit is sampled, the word's own DAC register takes the new value as soon as the word commits, even if the load input has risen since. A separate active-low clear acts at once, without waiting for a clock. It drives every main DAC register to the bias point, or to one sixteenth of it, and drives every sub DAC register to zero. The data registers keep their contents through a clear.

Bit 14 of the word set means a data write. Bit 13 then picks the sub register (1) or the main register (0), and bits 12:10 give the channel. A main value sits in bits 9:0 and a sub value in bits 7:0. Bit 14 clear with bit 13 set means a channel setup write: bits 12:10 give the channel and bits 1:0 the setting. Both bits clear means a global setup write from bits 1:0. Bit 0 of that value picks the clear level and bit 1 selects twos-complement coding. Bit 15 is ignored.

The receiver works as a state machine with four states. RX_IDLE means the frame sync is high. RX_SHIFT means a frame is open with fewer than 16 bits taken. RX_FULL means 16 bits have been taken. RX_OVER means an extra bit arrived. The transitions are:
- IDLE to SHIFT when the frame sync falls.
- SHIFT to FULL on the sixteenth falling edge.
- SHIFT to IDLE when the frame sync rises early; the word is discarded.
- FULL to IDLE when the frame sync rises; the word commits.
- FULL to OVER on a seventeenth falling edge.
- OVER to IDLE when the frame sync rises; the word is discarded.

Top module: `dac_serial_regs`

## Requirements
- R1: After reset every main DAC output is 0x200, every sub DAC output is 0, and all channel and global setup outputs are 0.
- R2: Bits are sampled on falling serial-clock edges, MSB first, only while fsync_n is low. A complete word takes effect after fsync_n rises. Serial-clock edges while fsync_n is high shift nothing.
- R3: A frame with fewer or more than 16 falling edges is discarded and changes no register.
- R4: Mode bits 14:13 = 00 write bits 1:0 to the global setup. Bits 12:2 are ignored and no channel register changes.
- R5: Mode bits 14:13 = 01 write bits 1:0 to the setup of the channel in bits 12:10. Other channels keep their setup.
- R6: With bit 14 set, the word writes the data register of channel 12:10: main from bits 9:0 when bit 13 is 0, sub from bits 7:0 when bit 13 is 1. While ldac_n stays high, no DAC output changes.
- R7: While ldac_n is low, every main and sub DAC register copies its data register.
- R8: If ldac_n is low at the sixteenth falling edge, the addressed DAC register takes the word's value when the word commits, even if ldac_n is high by then.
- R9: While clr_n is low, all main DAC outputs equal 0x200 (global bit 0 = 0) or 0x020 (global bit 0 = 1), and all sub DAC outputs equal 0. This takes effect without a clock edge, and data registers are kept.
- R10: When global bit 1 is set, a main value is taken as twos complement and stored with its bit 9 inverted, so 0x000 becomes 0x200 and 0x1FF becomes 0x3FF. Sub values are stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, data taken on its falling edge |
| fsync_n | input | 1 | Active-low frame sync |
| sdata | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Active-low load of all DAC registers |
| clr_n | input | 1 | Asynchronous active-low clear of the DAC registers |
| dac_main | output | NCH*MAIN_W | Main DAC registers, channel 0 in the low bits |
| dac_sub | output | NCH*SUB_W | Sub DAC registers, channel 0 in the low bits |
| ch_cfg | output | NCH*CFG_W | Per-channel setup registers |
| sys_cfg | output | 2 | Global setup: bit 0 clear level, bit 1 twos complement |

## Verification
Data words are sent to the main register of one channel, to the sub register of another, and to a third channel. This shows that data registers stay hidden until a load, and that a load moves every channel together. Values such as 0x155 and 0x3A5 are not bit-symmetric, so a reversed bit order or a wrong field would be caught. Frames of 12, 15 and 17 bits, and serial-clock toggling between frames, check that only exact 16-bit frames count. A load pulse that ends inside the frame checks the automatic update. Clears at both levels, followed by a load, check the clear values and that the data registers survive the clear.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
    localparam int FRAME_BITS   = 16;
    localparam int POS_DATA_SEL = 14;
    localparam int POS_SUB_SEL  = 13;
    localparam int POS_ADDR     = 10;
    localparam int SYS_W        = 2;
    localparam int SYS_CLR_LOW  = 0;
    localparam int SYS_TWOS     = 1;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_FULL  = 2'd2,
        RX_OVER  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import dacif_pkg::*;
#(
    parameter int WORD_W = FRAME_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              fsync_n,
    input  logic              sdata,
    input  logic              ldac_n,
    output logic              word_valid,
    output logic [WORD_W-2:0] word,
    output logic              auto_upd,
    output logic              ldac_sync_n
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [3:0]        syn;
    logic              sclk_s, fs_s, sd_s, ld_s;
    logic              sclk_prev, fall;
    logic [WORD_W-2:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              ldac_cap;
    rx_state_e         state, nxt;

    bit_sync #(.W(4), .RST_VAL(4'hF)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, fsync_n, sdata, ldac_n}),
        .q     (syn)
    );

    assign sclk_s      = syn[3];
    assign fs_s        = syn[2];
    assign sd_s        = syn[1];
    assign ld_s        = syn[0];
    assign fall        = sclk_prev & ~sclk_s;
    assign ldac_sync_n = ld_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (!fs_s) nxt = RX_SHIFT;
            RX_SHIFT: begin
                if (fs_s)                                     nxt = RX_IDLE;
                else if (fall && cnt == CNT_W'(WORD_W - 1))   nxt = RX_FULL;
            end
            RX_FULL: begin
                if (fs_s)      nxt = RX_IDLE;
                else if (fall) nxt = RX_OVER;
            end
            RX_OVER:  if (fs_s) nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev  <= 1'b1;
            shreg      <= '0;
            cnt        <= '0;
            ldac_cap   <= 1'b1;
            word_valid <= 1'b0;
            word       <= '0;
            auto_upd   <= 1'b0;
        end else begin
            sclk_prev  <= sclk_s;
            word_valid <= 1'b0;
            unique case (state)
                RX_IDLE:  cnt <= '0;
                RX_SHIFT: begin
                    if (!fs_s && fall) begin
                        shreg <= {shreg[WORD_W-3:0], sd_s};
                        cnt   <= cnt + 1'b1;
                        if (cnt == CNT_W'(WORD_W - 1)) ldac_cap <= ld_s;
                    end
                end
                RX_FULL: begin
                    if (fs_s) begin
                        word_valid <= 1'b1;
                        word       <= shreg;
                        auto_upd   <= ~ldac_cap;
                    end
                end
                RX_OVER: ;
            endcase
        end
    end

    AST_SHIFT_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_SHIFT) |-> (cnt < CNT_W'(WORD_W))); // R3
    AST_COMMIT_EXACT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> ($past(cnt) == CNT_W'(WORD_W))); // R3
    AST_COMMIT_AFTER_FS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(fs_s)); // R2
endmodule

// File: rtl/ctrl_decode.sv
module ctrl_decode
    import dacif_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int MAIN_W = 10,
    parameter int SUB_W  = 8,
    parameter int CFG_W  = 2,
    parameter int ADDR_W = $clog2(NCH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    word_valid,
    input  logic [FRAME_BITS-2:0]   word,
    output logic [SYS_W-1:0]        sys_cfg,
    output logic [NCH*CFG_W-1:0]    ch_cfg,
    output logic                    wr_main,
    output logic                    wr_sub,
    output logic [ADDR_W-1:0]       addr,
    output logic [MAIN_W-1:0]       main_val,
    output logic [SUB_W-1:0]        sub_val
);
    localparam logic [MAIN_W-1:0] MID = {1'b1, {(MAIN_W-1){1'b0}}};

    logic             is_data, is_sys, is_chan;
    logic [CFG_W-1:0] cfg_q [NCH];

    assign is_data  = word_valid &  word[POS_DATA_SEL];
    assign is_sys   = word_valid & ~word[POS_DATA_SEL] & ~word[POS_SUB_SEL];
    assign is_chan  = word_valid & ~word[POS_DATA_SEL] &  word[POS_SUB_SEL];
    assign wr_main  = is_data & ~word[POS_SUB_SEL];
    assign wr_sub   = is_data &  word[POS_SUB_SEL];
    assign addr     = word[POS_ADDR +: ADDR_W];
    assign main_val = word[MAIN_W-1:0] ^ (sys_cfg[SYS_TWOS] ? MID : '0);
    assign sub_val  = word[SUB_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_cfg <= '0;
            for (int i = 0; i < NCH; i++) cfg_q[i] <= '0;
        end else begin
            if (is_sys) sys_cfg <= word[SYS_W-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (is_chan && addr == ADDR_W'(i)) cfg_q[i] <= word[CFG_W-1:0];
            end
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_cfg_out
        assign ch_cfg[g*CFG_W +: CFG_W] = cfg_q[g];
    end

    AST_SYS_ONLY_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sys_cfg) |-> $past(word_valid)); // R4
    AST_CHAN_ONLY_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ch_cfg) |-> $past(word_valid)); // R5
endmodule

// File: rtl/dac_bank.sv
module dac_bank #(
    parameter int NCH    = 8,
    parameter int MAIN_W = 10,
    parameter int SUB_W  = 8,
    parameter int ADDR_W = $clog2(NCH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_n,
    input  logic                  ldac_n,
    input  logic                  auto_upd,
    input  logic                  wr_main,
    input  logic                  wr_sub,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [MAIN_W-1:0]     main_val,
    input  logic [SUB_W-1:0]      sub_val,
    input  logic                  clr_low,
    output logic [NCH*MAIN_W-1:0] dac_main,
    output logic [NCH*SUB_W-1:0]  dac_sub
);
    localparam logic [MAIN_W-1:0] MID     = {1'b1, {(MAIN_W-1){1'b0}}};
    localparam logic [MAIN_W-1:0] MID_DIV = MID >> 4;

    logic [MAIN_W-1:0]     data_main [NCH];
    logic [SUB_W-1:0]      data_sub  [NCH];
    logic [NCH*MAIN_W-1:0] data_main_flat;
    logic [MAIN_W-1:0]     clr_val;
    logic                  arst_n;
    logic                  any_auto;

    assign clr_val  = clr_low ? MID_DIV : MID;
    assign arst_n   = rst_n & clr_n;
    assign any_auto = auto_upd & (wr_main | wr_sub);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                data_main[i] <= MID;
                data_sub[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (wr_main && addr == ADDR_W'(i)) data_main[i] <= main_val;
                if (wr_sub  && addr == ADDR_W'(i)) data_sub[i]  <= sub_val;
            end
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic              hit_main, hit_sub;
        logic [MAIN_W-1:0] dm;
        logic [SUB_W-1:0]  ds;

        assign hit_main = wr_main & auto_upd & (addr == ADDR_W'(g));
        assign hit_sub  = wr_sub  & auto_upd & (addr == ADDR_W'(g));

        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                dm <= clr_val;
                ds <= '0;
            end else begin
                if (hit_main)     dm <= main_val;
                else if (!ldac_n) dm <= data_main[g];
                if (hit_sub)      ds <= sub_val;
                else if (!ldac_n) ds <= data_sub[g];
            end
        end

        assign dac_main[g*MAIN_W +: MAIN_W] = dm;
        assign dac_sub[g*SUB_W +: SUB_W]    = ds;
        assign data_main_flat[g*MAIN_W +: MAIN_W] = data_main[g];

        AST_AUTO_UPDATE_MAIN: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
            hit_main |=> (dm == $past(main_val))); // R8
    end

    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (ldac_n && !any_auto) |=> ($stable(dac_main) && $stable(dac_sub))); // R6
    AST_LOAD_COPIES_DATA: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (!ldac_n && !wr_main) |=> (dac_main == $past(data_main_flat))); // R7
    AST_CLEAR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && $stable(clr_low)) |-> ((dac_main == {NCH{clr_val}}) && (dac_sub == '0))); // R9
endmodule

// File: rtl/dac_serial_regs.sv
module dac_serial_regs
    import dacif_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int MAIN_W = 10,
    parameter int SUB_W  = 8,
    parameter int CFG_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  fsync_n,
    input  logic                  sdata,
    input  logic                  ldac_n,
    input  logic                  clr_n,
    output logic [NCH*MAIN_W-1:0] dac_main,
    output logic [NCH*SUB_W-1:0]  dac_sub,
    output logic [NCH*CFG_W-1:0]  ch_cfg,
    output logic [SYS_W-1:0]      sys_cfg
);
    localparam int ADDR_W = $clog2(NCH);

    logic                  word_valid, auto_upd, ldac_sync_n;
    logic [FRAME_BITS-2:0] word;
    logic                  wr_main, wr_sub;
    logic [ADDR_W-1:0]     addr;
    logic [MAIN_W-1:0]     main_val;
    logic [SUB_W-1:0]      sub_val;

    serial_rx #(.WORD_W(FRAME_BITS)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk        (sclk),
        .fsync_n     (fsync_n),
        .sdata       (sdata),
        .ldac_n      (ldac_n),
        .word_valid  (word_valid),
        .word        (word),
        .auto_upd    (auto_upd),
        .ldac_sync_n (ldac_sync_n)
    );

    ctrl_decode #(.NCH(NCH), .MAIN_W(MAIN_W), .SUB_W(SUB_W), .CFG_W(CFG_W), .ADDR_W(ADDR_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word       (word),
        .sys_cfg    (sys_cfg),
        .ch_cfg     (ch_cfg),
        .wr_main    (wr_main),
        .wr_sub     (wr_sub),
        .addr       (addr),
        .main_val   (main_val),
        .sub_val    (sub_val)
    );

    dac_bank #(.NCH(NCH), .MAIN_W(MAIN_W), .SUB_W(SUB_W), .ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .ldac_n   (ldac_sync_n),
        .auto_upd (auto_upd),
        .wr_main  (wr_main),
        .wr_sub   (wr_sub),
        .addr     (addr),
        .main_val (main_val),
        .sub_val  (sub_val),
        .clr_low  (sys_cfg[SYS_CLR_LOW]),
        .dac_main (dac_main),
        .dac_sub  (dac_sub)
    );
endmodule

// File: tb/sim_dac_serial_regs.sv
`timescale 1ns/1ps
module sim_dac_serial_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1, fsync_n = 1'b1, sdata = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
    logic [79:0] dac_main;
    logic [63:0] dac_sub;
    logic [15:0] ch_cfg;
    logic [1:0]  sys_cfg;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    dac_serial_regs u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync_n(fsync_n), .sdata(sdata),
        .ldac_n(ldac_n), .clr_n(clr_n), .dac_main(dac_main), .dac_sub(dac_sub),
        .ch_cfg(ch_cfg), .sys_cfg(sys_cfg)
    );

    function automatic logic [15:0] mk_data(input bit sub, input int ch, input logic [9:0] v);
        return {1'b0, 1'b1, sub, 3'(ch), v};
    endfunction
    function automatic logic [15:0] mk_chan(input int ch, input logic [1:0] c);
        return {1'b0, 2'b01, 3'(ch), 8'h00, c};
    endfunction
    function automatic logic [15:0] mk_sys(input logic [1:0] v);
        return {1'b1, 2'b00, 3'b111, 8'hA5, v};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] mainv(input int ch);
        return dac_main[ch*10 +: 10];
    endfunction
    function automatic logic [7:0] subv(input int ch);
        return dac_sub[ch*8 +: 8];
    endfunction

    task automatic send(input logic [15:0] w, input int nbits, input bit ldac16);
        fsync_n = 1'b0;
        wait_clk(4);
        for (int k = 0; k < nbits; k++) begin
            sdata = (k < 16) ? w[15-k] : 1'b0;
            if (ldac16 && k == nbits - 1) ldac_n = 1'b0;
            wait_clk(4);
            sclk = 1'b0;
            wait_clk(4);
            sclk = 1'b1;
            if (ldac16 && k == nbits - 1) ldac_n = 1'b1;
        end
        wait_clk(4);
        fsync_n = 1'b1;
        wait_clk(14);
    endtask

    task automatic pulse_ldac();
        ldac_n = 1'b0;
        wait_clk(6);
        ldac_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic t_reset();
        chk("R1 main reset", dac_main, {8{10'h200}});
        chk("R1 sub reset", dac_sub, 64'h0);
        chk("R1 chan cfg reset", ch_cfg, 16'h0);
        chk("R1 sys cfg reset", sys_cfg, 2'd0);
    endtask

    task automatic t_double_buffer();
        send(mk_data(1'b0, 2, 10'h155), 16, 1'b0);
        send(mk_data(1'b1, 5, 10'h3A5), 16, 1'b0);
        send(mk_data(1'b0, 0, 10'h3FF), 16, 1'b0);
        chk("R6 main held without load", dac_main, {8{10'h200}});
        chk("R6 sub held without load", dac_sub, 64'h0);
        pulse_ldac();
        chk("R7 R2 ch2 main loaded", mainv(2), 10'h155);
        chk("R7 ch0 main loaded", mainv(0), 10'h3FF);
        chk("R7 ch1 main unchanged", mainv(1), 10'h200);
        chk("R7 R6 ch5 sub loaded low byte", subv(5), 8'hA5);
    endtask

    task automatic t_idle_edges();
        sdata = 1'b1;
        for (int k = 0; k < 6; k++) begin
            sclk = 1'b0; wait_clk(4);
            sclk = 1'b1; wait_clk(4);
        end
        send(mk_data(1'b0, 1, 10'h0C3), 16, 1'b0);
        pulse_ldac();
        chk("R2 edges outside frame ignored", mainv(1), 10'h0C3);
    endtask

    task automatic t_chan_cfg();
        send(mk_chan(3, 2'b10), 16, 1'b0);
        chk("R5 channel 3 setup only", ch_cfg, 16'h0080);
    endtask

    task automatic t_sys_cfg();
        send(mk_sys(2'b01), 16, 1'b0);
        chk("R4 global setup written", sys_cfg, 2'b01);
        chk("R4 channel setup untouched", ch_cfg, 16'h0080);
    endtask

    task automatic t_bad_frames();
        send(mk_data(1'b0, 1, 10'h2AA), 15, 1'b0);
        send(mk_data(1'b0, 1, 10'h2AA), 17, 1'b0);
        send(mk_chan(3, 2'b01), 12, 1'b0);
        pulse_ldac();
        chk("R3 short and long data frames dropped", mainv(1), 10'h0C3);
        chk("R3 short setup frame dropped", ch_cfg, 16'h0080);
    endtask

    task automatic t_auto_update();
        send(mk_data(1'b0, 4, 10'h123), 16, 1'b1);
        chk("R8 main auto update", mainv(4), 10'h123);
        send(mk_data(1'b1, 6, 10'h03C), 16, 1'b1);
        chk("R8 sub auto update", subv(6), 8'h3C);
        chk("R8 other channel kept", mainv(2), 10'h155);
    endtask

    task automatic t_clear();
        @(negedge clk);
        clr_n = 1'b0;
        #1;
        chk("R9 async clear to low level", dac_main, {8{10'h020}});
        chk("R9 async clear of sub", dac_sub, 64'h0);
        wait_clk(5);
        clr_n = 1'b1;
        wait_clk(4);
        chk("R9 level kept after release", dac_main, {8{10'h020}});
        send(mk_sys(2'b00), 16, 1'b0);
        @(negedge clk);
        clr_n = 1'b0;
        #1;
        chk("R9 clear to bias point", dac_main, {8{10'h200}});
        wait_clk(5);
        clr_n = 1'b1;
        wait_clk(4);
        pulse_ldac();
        chk("R9 data kept ch2", mainv(2), 10'h155);
        chk("R9 data kept ch4", mainv(4), 10'h123);
        chk("R9 data kept ch0", mainv(0), 10'h3FF);
        chk("R9 sub data kept ch6", subv(6), 8'h3C);
        chk("R9 sub data kept ch5", subv(5), 8'hA5);
    endtask

    task automatic t_twos();
        send(mk_sys(2'b10), 16, 1'b0);
        chk("R10 twos complement selected", sys_cfg, 2'b10);
        send(mk_data(1'b0, 7, 10'h1FF), 16, 1'b1);
        chk("R10 0x1FF stored as 0x3FF", mainv(7), 10'h3FF);
        send(mk_data(1'b0, 6, 10'h200), 16, 1'b1);
        chk("R10 0x200 stored as 0x000", mainv(6), 10'h000);
        send(mk_data(1'b1, 7, 10'h080), 16, 1'b1);
        chk("R10 sub not converted", subv(7), 8'h80);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_double_buffer();
        t_idle_edges();
        t_chan_cfg();
        t_sys_cfg();
        t_bad_frames();
        t_auto_update();
        t_clear();
        t_twos();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule